// File: doc/BRIEF.md
# Write-Back Slot Scheduling Queue

This block keeps the timetable of register-file writes for a pipelined processor. When the decoder issues an instruction, it may hand over up to two planned writes, one per column. Each planned write carries a destination register, a write mask, a crossbar source selector and a predicted latency in cycles. The entry does not go to the tail of the queue. It goes straight into the slot from which it will reach the head after exactly that many clock edges. The whole queue moves one slot toward the head on every edge.

Each column's head slot drives the register-write cycle with the register number and the mask. The slot just behind the head drives the crossbar source select, one cycle early. A comparator on every slot lets the hazard logic ask whether a given register has a write still in flight, and how soon the earliest such write lands. If a requested slot is already taken, the block raises a per-column stall and leaves the queue unchanged for that column.

Top module: `wbq_sched`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every output valid flag is 0 (wr_vld_*, xsel_vld_*, qry_hit) and both stall flags are 0.
- R2: A write accepted with latency k (1 to DEPTH) is sampled at a rising edge. It shows on that column's wr_vld/wr_reg/wr_mask after exactly k rising edges, counting the sampling edge. Before that, wr_vld of that column shows nothing for it.
- R3: For k of 2 or more, the entry's write-port selector shows on xsel_vld/xsel_port of its column in the cycle before it reaches the head.
- R4: The two columns work independently. One issue can place writes with different latencies in column A and column B, and each write reaches its own head on its own schedule.
- R5: An insert is refused when its target slot would still hold a valid entry after the shift. That happens when the column already holds an entry whose remaining latency equals k. In that case the column's stall output is 1 in the same cycle, the new write is dropped, and the resident entry stays unchanged.
- R6: An insert whose latency is 0 or greater than DEPTH is ignored: no entry is created and stall stays 0.
- R7: A synchronous flush empties both columns at the next edge. Any insert in the flush cycle is dropped, and stall stays 0 during flush.
- R8: qry_hit is 1 exactly when some valid entry in either column has a register number equal to qry_reg.
- R9: On a hit, qry_lat gives the smallest number of edges until a matching entry reaches the head. A value of 0 means the match is on a head output now.
- R10: A head entry is shown for a single cycle. Slots vacated at the tail are filled with invalid entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all queued writes |
| ins_vld_a | input | 1 | Column A insert request |
| ins_lat_a | input | LAT_W | Column A predicted latency |
| ins_reg_a | input | 6 | Column A destination register |
| ins_mask_a | input | 2 | Column A write mask |
| ins_port_a | input | 4 | Column A crossbar source selector |
| ins_vld_b | input | 1 | Column B insert request |
| ins_lat_b | input | LAT_W | Column B predicted latency |
| ins_reg_b | input | 6 | Column B destination register |
| ins_mask_b | input | 2 | Column B write mask |
| ins_port_b | input | 4 | Column B crossbar source selector |
| qry_reg | input | 6 | Register number probed for pending writes |
| stall_a | output | 1 | Column A insert collided |
| stall_b | output | 1 | Column B insert collided |
| wr_vld_a | output | 1 | Column A head write valid |
| wr_reg_a | output | 6 | Column A head register |
| wr_mask_a | output | 2 | Column A head mask |
| wr_vld_b | output | 1 | Column B head write valid |
| wr_reg_b | output | 6 | Column B head register |
| wr_mask_b | output | 2 | Column B head mask |
| xsel_vld_a | output | 1 | Column A crossbar select valid (next head) |
| xsel_port_a | output | 4 | Column A crossbar source selector |
| xsel_vld_b | output | 1 | Column B crossbar select valid (next head) |
| xsel_port_b | output | 4 | Column B crossbar source selector |
| qry_hit | output | 1 | A pending write matches qry_reg |
| qry_lat | output | IDX_W | Edges until the nearest match reaches the head |

## Verification
The bench counts edges from each insert and checks latencies 1, 3 and DEPTH. An off-by-one slot index would make a write land a cycle early or late, and the crossbar select would no longer lead the head. Collision is provoked by a resident entry whose remaining latency equals the new request. A design that overwrites instead of stalling would lose the resident write and report a pending write that never lands. Latencies of 0 and DEPTH+1 check that out-of-range requests are not wrapped into a slot. A flush issued together with an insert shows whether flush really takes priority. Two matches for one register in different columns check that the query returns the nearer one rather than the first column's.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
  localparam int REG_W  = 6;
  localparam int MASK_W = 2;
  localparam int PORT_W = 4;

  typedef struct packed {
    logic              vld;
    logic [REG_W-1:0]  rnum;
    logic [MASK_W-1:0] mask;
    logic [PORT_W-1:0] port;
  } wbq_ent_t;
endpackage

// File: rtl/wbq_column.sv
// One column of the write-back timetable: slot 0 is the head.
module wbq_column
  import wbq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LAT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ins_vld,
  input  logic [LAT_W-1:0] ins_lat,
  input  wbq_ent_t         ins_ent,
  input  logic [REG_W-1:0] qry_reg,
  output logic             stall,
  output wbq_ent_t         head,
  output wbq_ent_t         near,
  output logic [DEPTH-1:0] match
);

  wbq_ent_t         q   [DEPTH];
  wbq_ent_t         shf [DEPTH];
  wbq_ent_t         d   [DEPTH];
  logic [DEPTH-1:0] sel;
  logic [DEPTH-1:0] busy;
  logic [DEPTH-1:0] en;
  logic             lat_ok;
  logic             take;

  assign lat_ok = (ins_lat != '0) && (ins_lat <= LAT_W'(DEPTH));
  assign take   = ins_vld && lat_ok && !flush;

  // shifted view and per-slot register comparators
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == DEPTH - 1) begin : g_tail
      assign shf[i] = '0;
    end else begin : g_body
      assign shf[i] = q[i+1];
    end
    assign busy[i]  = shf[i].vld;
    assign match[i] = q[i].vld && (q[i].rnum == qry_reg);
  end

  // next state: shift, then place the new entry if its slot is free
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      sel[i] = take && (ins_lat == LAT_W'(i + 1));
      d[i]   = shf[i];
      if (sel[i] && !busy[i]) begin
        d[i]     = ins_ent;
        d[i].vld = 1'b1;
      end
      if (flush) d[i] = '0;
      en[i] = flush || sel[i] || q[i].vld || shf[i].vld;
    end
  end

  assign stall = |(sel & busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (en[i]) q[i] <= d[i];
      end
    end
  end

  assign head = q[0];
  assign near = q[1];

endmodule

// File: rtl/wbq_nearest.sv
// Lowest-index set bit of a request vector.
module wbq_nearest #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/wbq_sched.sv
module wbq_sched
  import wbq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LAT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              ins_vld_a,
  input  logic [LAT_W-1:0]  ins_lat_a,
  input  logic [REG_W-1:0]  ins_reg_a,
  input  logic [MASK_W-1:0] ins_mask_a,
  input  logic [PORT_W-1:0] ins_port_a,
  input  logic              ins_vld_b,
  input  logic [LAT_W-1:0]  ins_lat_b,
  input  logic [REG_W-1:0]  ins_reg_b,
  input  logic [MASK_W-1:0] ins_mask_b,
  input  logic [PORT_W-1:0] ins_port_b,
  input  logic [REG_W-1:0]  qry_reg,
  output logic              stall_a,
  output logic              stall_b,
  output logic              wr_vld_a,
  output logic [REG_W-1:0]  wr_reg_a,
  output logic [MASK_W-1:0] wr_mask_a,
  output logic              wr_vld_b,
  output logic [REG_W-1:0]  wr_reg_b,
  output logic [MASK_W-1:0] wr_mask_b,
  output logic              xsel_vld_a,
  output logic [PORT_W-1:0] xsel_port_a,
  output logic              xsel_vld_b,
  output logic [PORT_W-1:0] xsel_port_b,
  output logic              qry_hit,
  output logic [IDX_W-1:0]  qry_lat
);

  wbq_ent_t         ent_a, ent_b;
  wbq_ent_t         head_a, head_b, near_a, near_b;
  logic [DEPTH-1:0] match_a, match_b;

  assign ent_a = '{vld: 1'b1, rnum: ins_reg_a, mask: ins_mask_a, port: ins_port_a};
  assign ent_b = '{vld: 1'b1, rnum: ins_reg_b, mask: ins_mask_b, port: ins_port_b};

  wbq_column #(.DEPTH(DEPTH)) u_col_a (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ins_vld(ins_vld_a), .ins_lat(ins_lat_a), .ins_ent(ent_a),
    .qry_reg(qry_reg), .stall(stall_a),
    .head(head_a), .near(near_a), .match(match_a)
  );

  wbq_column #(.DEPTH(DEPTH)) u_col_b (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ins_vld(ins_vld_b), .ins_lat(ins_lat_b), .ins_ent(ent_b),
    .qry_reg(qry_reg), .stall(stall_b),
    .head(head_b), .near(near_b), .match(match_b)
  );

  // slot-wise merge of both columns, nearest slot wins
  wbq_nearest #(.DEPTH(DEPTH)) u_nearest (
    .req(match_a | match_b),
    .any(qry_hit),
    .idx(qry_lat)
  );

  assign wr_vld_a    = head_a.vld;
  assign wr_reg_a    = head_a.rnum;
  assign wr_mask_a   = head_a.mask;
  assign wr_vld_b    = head_b.vld;
  assign wr_reg_b    = head_b.rnum;
  assign wr_mask_b   = head_b.mask;
  assign xsel_vld_a  = near_a.vld;
  assign xsel_port_a = near_a.port;
  assign xsel_vld_b  = near_b.vld;
  assign xsel_port_b = near_b.port;

endmodule

// File: rtl/wbq_sched_chk.sv
module wbq_sched_chk
  import wbq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LAT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              ins_vld_a,
  input logic [LAT_W-1:0]  ins_lat_a,
  input logic [REG_W-1:0]  ins_reg_a,
  input logic [MASK_W-1:0] ins_mask_a,
  input logic              ins_vld_b,
  input logic [LAT_W-1:0]  ins_lat_b,
  input logic [REG_W-1:0]  qry_reg,
  input logic              stall_a,
  input logic              stall_b,
  input logic              wr_vld_a,
  input logic [REG_W-1:0]  wr_reg_a,
  input logic [MASK_W-1:0] wr_mask_a,
  input logic              wr_vld_b,
  input logic [REG_W-1:0]  wr_reg_b,
  input logic              xsel_vld_a,
  input logic              xsel_vld_b,
  input logic              qry_hit,
  input logic [IDX_W-1:0]  qry_lat
);

  assert_lat1_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_vld_a && ins_lat_a == LAT_W'(1) && !stall_a && !flush)
      |=> (wr_vld_a && wr_reg_a == $past(ins_reg_a) && wr_mask_a == $past(ins_mask_a)));

  assert_xsel_leads_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xsel_vld_a && !flush) |=> wr_vld_a);

  assert_stall_needs_insert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_a || stall_b) |-> !flush && ((stall_a && ins_vld_a) || !stall_a)
                                    && ((stall_b && ins_vld_b) || !stall_b));

  assert_bad_lat_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_lat_a == '0 || ins_lat_a > LAT_W'(DEPTH)) |-> !stall_a);

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!wr_vld_a && !wr_vld_b && !xsel_vld_a && !xsel_vld_b && !qry_hit));

  assert_query_at_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_hit && qry_lat == '0)
      |-> ((wr_vld_a && wr_reg_a == qry_reg) || (wr_vld_b && wr_reg_b == qry_reg)));

endmodule

bind wbq_sched wbq_sched_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_wbq_sched.sv
`timescale 1ns/1ps
module tb_wbq_sched;
  localparam int DEPTH = 8;
  localparam int LAT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);
  localparam real HALF = 10.0;

  logic clk = 1'b0;
  logic rst_n;
  logic flush;
  logic ins_vld_a, ins_vld_b;
  logic [LAT_W-1:0] ins_lat_a, ins_lat_b;
  logic [5:0] ins_reg_a, ins_reg_b;
  logic [1:0] ins_mask_a, ins_mask_b;
  logic [3:0] ins_port_a, ins_port_b;
  logic [5:0] qry_reg;
  logic stall_a, stall_b;
  logic wr_vld_a, wr_vld_b;
  logic [5:0] wr_reg_a, wr_reg_b;
  logic [1:0] wr_mask_a, wr_mask_b;
  logic xsel_vld_a, xsel_vld_b;
  logic [3:0] xsel_port_a, xsel_port_b;
  logic qry_hit;
  logic [IDX_W-1:0] qry_lat;

  int checks = 0;
  int errors = 0;

  always #(HALF) clk = ~clk;

  wbq_sched #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    flush = 0; ins_vld_a = 0; ins_vld_b = 0;
    ins_lat_a = '0; ins_lat_b = '0;
    ins_reg_a = '0; ins_reg_b = '0; ins_mask_a = '0; ins_mask_b = '0;
    ins_port_a = '0; ins_port_b = '0;
  endtask

  task automatic drain();
    idle();
    repeat (DEPTH + 1) step();
  endtask

  task automatic probe(input logic [5:0] r, input string tag, input int hit, input int lat);
    qry_reg = r;
    #1;
    chk({tag, " hit"}, int'(qry_hit), hit);
    if (hit == 1) chk({tag, " lat"}, int'(qry_lat), lat);
  endtask

  task automatic t_reset();
    chk("R1 wr_vld_a in reset", int'(wr_vld_a), 0);
    chk("R1 wr_vld_b in reset", int'(wr_vld_b), 0);
    chk("R1 xsel in reset", int'(xsel_vld_a | xsel_vld_b), 0);
    chk("R1 qry_hit in reset", int'(qry_hit), 0);
    chk("R1 stall in reset", int'(stall_a | stall_b), 0);
  endtask

  task automatic t_latency(input int k, input logic [5:0] r, input logic [1:0] m, input logic [3:0] p);
    ins_vld_a = 1; ins_lat_a = LAT_W'(k); ins_reg_a = r; ins_mask_a = m; ins_port_a = p;
    step();
    idle();
    for (int e = 1; e < k; e++) begin
      chk("R2 early head", int'(wr_vld_a), 0);
      if (e == k - 1) begin
        chk("R3 xsel valid", int'(xsel_vld_a), 1);
        chk("R3 xsel port", int'(xsel_port_a), int'(p));
      end
      step();
    end
    chk("R2 head valid", int'(wr_vld_a), 1);
    chk("R2 head reg", int'(wr_reg_a), int'(r));
    chk("R2 head mask", int'(wr_mask_a), int'(m));
    step();
    chk("R10 head gone", int'(wr_vld_a), 0);
  endtask

  task automatic t_two_cols();
    ins_vld_a = 1; ins_lat_a = LAT_W'(2); ins_reg_a = 6'd5; ins_mask_a = 2'd2; ins_port_a = 4'd3;
    ins_vld_b = 1; ins_lat_b = LAT_W'(5); ins_reg_b = 6'd7; ins_mask_b = 2'd1; ins_port_b = 4'd9;
    step();
    idle();
    probe(6'd7, "R4 col b pending", 1, 4);
    probe(6'd5, "R4 col a pending", 1, 1);
    step();
    chk("R4 col a lands", int'(wr_vld_a), 1);
    chk("R4 col a reg", int'(wr_reg_a), 5);
    chk("R4 col b not yet", int'(wr_vld_b), 0);
    step(); step();
    chk("R3 col b xsel", int'(xsel_vld_b), 1);
    chk("R3 col b port", int'(xsel_port_b), 9);
    step();
    chk("R4 col b lands", int'(wr_vld_b), 1);
    chk("R4 col b reg", int'(wr_reg_b), 7);
    chk("R4 col b mask", int'(wr_mask_b), 1);
    chk("R10 col a empty", int'(wr_vld_a), 0);
  endtask

  task automatic t_collision();
    ins_vld_a = 1; ins_lat_a = LAT_W'(4); ins_reg_a = 6'd20; ins_mask_a = 2'd1;
    step();
    ins_lat_a = LAT_W'(3); ins_reg_a = 6'd21; ins_mask_a = 2'd3;
    #1;
    chk("R5 stall_a raised", int'(stall_a), 1);
    chk("R5 stall_b quiet", int'(stall_b), 0);
    step();
    idle();
    probe(6'd21, "R5 dropped entry", 0, 0);
    probe(6'd20, "R5 resident kept", 1, 2);
    step(); step();
    chk("R5 resident lands", int'(wr_vld_a), 1);
    chk("R5 resident reg", int'(wr_reg_a), 20);
    chk("R5 resident mask", int'(wr_mask_a), 1);
  endtask

  task automatic t_range();
    ins_vld_a = 1; ins_lat_a = '0; ins_reg_a = 6'd40;
    ins_vld_b = 1; ins_lat_b = LAT_W'(DEPTH + 1); ins_reg_b = 6'd41;
    #1;
    chk("R6 no stall lat0", int'(stall_a), 0);
    chk("R6 no stall lat big", int'(stall_b), 0);
    step();
    idle();
    probe(6'd40, "R6 lat0 ignored", 0, 0);
    probe(6'd41, "R6 big lat ignored", 0, 0);
    for (int e = 0; e < DEPTH; e++) begin
      chk("R6 no write", int'(wr_vld_a | wr_vld_b), 0);
      step();
    end
  endtask

  task automatic t_flush();
    ins_vld_a = 1; ins_lat_a = LAT_W'(3); ins_reg_a = 6'd50;
    ins_vld_b = 1; ins_lat_b = LAT_W'(6); ins_reg_b = 6'd51;
    step();
    idle();
    flush = 1; ins_vld_a = 1; ins_lat_a = LAT_W'(1); ins_reg_a = 6'd52;
    #1;
    chk("R7 no stall in flush", int'(stall_a | stall_b), 0);
    step();
    idle();
    chk("R7 col a empty", int'(wr_vld_a), 0);
    chk("R7 col b empty", int'(wr_vld_b), 0);
    probe(6'd50, "R7 old a gone", 0, 0);
    probe(6'd51, "R7 old b gone", 0, 0);
    probe(6'd52, "R7 same-cycle insert dropped", 0, 0);
    for (int e = 0; e < DEPTH; e++) begin
      chk("R7 stays empty", int'(wr_vld_a | wr_vld_b), 0);
      step();
    end
  endtask

  task automatic t_query();
    ins_vld_a = 1; ins_lat_a = LAT_W'(6); ins_reg_a = 6'd9;
    ins_vld_b = 1; ins_lat_b = LAT_W'(3); ins_reg_b = 6'd9;
    step();
    idle();
    probe(6'd9, "R9 nearest across columns", 1, 2);
    probe(6'd10, "R8 other register", 0, 0);
    step(); step();
    probe(6'd9, "R9 match at head", 1, 0);
    chk("R8 col b head reg", int'(wr_reg_b), 9);
    step();
    probe(6'd9, "R9 next match", 1, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    qry_reg = 6'd63;
    idle();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_latency(1, 6'd11, 2'd1, 4'd2);
    drain();
    t_latency(3, 6'd13, 2'd3, 4'd6);
    drain();
    t_latency(DEPTH, 6'd33, 2'd2, 4'd15);
    drain();
    t_two_cols();
    drain();
    t_collision();
    drain();
    t_range();
    drain();
    t_flush();
    drain();
    t_query();
    drain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule